// File: doc/BRIEF.md
# IPv4 Header Field Extractor

This block watches an Ethernet frame that arrives one byte per clock. Each byte comes with a frame-valid flag and the byte's absolute position in the frame. The block looks at the two type bytes that follow the MAC addresses. When they name IPv4, it captures the fixed 20-byte IPv4 header that comes next. The captured fields are the version/header-length byte, the total length, the protocol number, and the source and destination addresses.

Once the last header byte has been seen, the block checks three things: the version, the header length, and the one's-complement header checksum. A header that passes all three produces a single-cycle valid pulse while the captured fields sit unchanged on the outputs. A header that fails raises one flag per failed check, and no pulse is produced. A frame whose type is not IPv4 is dropped without any indication. A downstream classifier uses the pulse as its trigger to read the address and protocol outputs.

Top module: `ipv4_hdr_extract`

## Requirements
- R1: While reset is high, and after it is released, every output is zero and the block waits for a frame.
- R2: A frame starts when frame-valid is high with index 0. The header is parsed only when byte 12 equals 0x08 and byte 13 equals 0x00. Any other type pair drops the frame silently: no pulse, all flags zero, and all field outputs zero.
- R3: Header bytes are captured by frame index as follows. Index 14 is the version/IHL byte. Indices 16–17 are the total length. Index 23 is the protocol. Indices 26–29 are the source address and indices 30–33 are the destination address. Multi-byte fields are big-endian, so the lowest index lands in the most significant byte.
- R4: The ten 16-bit words at indices 14–33 are summed in one's complement, with the high byte at the even index. The sum includes the checksum word, and carries are folded back in. The checksum passes only when the result is 0xFFFF. `csumOk` shows a pass and `csumErr` shows a fail.
- R5: `verErr` is set when the upper nibble of the version/IHL byte is not 4.
- R6: `ihlErr` is set when the lower nibble of the version/IHL byte is not 5.
- R7: `hdrValid` is high for exactly one cycle, only when all three checks pass. It is sampled high in the second clock after the clock that takes index 33.
- R8: Flags, `csumOk` and field outputs keep their values until the next frame start. At that start they all clear to zero in the same clock.
- R9: If frame-valid drops before index 33 is taken, the frame is abandoned. There is no pulse and no flag.
- R10: Bytes after index 33 of the same frame, with frame-valid still high, change no output. They also start no new frame.
- R11: When several checks fail in one header, each matching flag is set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frameValid | input | 1 | High while frame bytes are presented |
| byteIdx | input | 6 | Absolute index of the present byte within the frame |
| rxByte | input | 8 | Frame byte |
| hdrValid | output | 1 | One-cycle pulse for a header that passes every check |
| csumOk | output | 1 | Header checksum passed |
| csumErr | output | 1 | Header checksum failed |
| verErr | output | 1 | Version nibble is not 4 |
| ihlErr | output | 1 | Header-length nibble is not 5 |
| verIhl | output | 8 | Captured version/IHL byte |
| totLen | output | 16 | Captured total length |
| proto | output | 8 | Captured protocol number |
| srcAddr | output | 32 | Captured source address |
| dstAddr | output | 32 | Captured destination address |

## Verification
Several properties are checked on every cycle:
- the pulse lasts one cycle and only follows a passing check;
- the parse state is entered only on a matching type pair;
- a dropped frame-valid returns the controller to idle;
- fields and flags move only on a capture, check or frame-start strobe;
- the checksum accumulator never leaves its range.

The actual byte positions, endianness, checksum arithmetic and clearing at the next frame start can only be shown by the bench's frames. These include directed valid, corrupted, foreign-type, truncated and payload-bearing frames, plus randomly built headers compared against a bench checksum model.

// File: rtl/ipv4_ext_pkg.sv
package ipv4_ext_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_ET,
    ST_PARSE,
    ST_CHECK,
    ST_EMIT
  } fsm_state_t;

  typedef struct packed {
    logic clearAll;    // new frame: wipe fields, flags, accumulator
    logic etHiLoad;    // hold first type byte
    logic hdrCapture;  // header byte present at rxByte
    logic setFlags;    // latch check results
  } ctrl_strobe_t;

endpackage

// File: rtl/ipv4_csum_acc.sv
module ipv4_csum_acc #(
  parameter int HDR_WORDS = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        wordEn,
  input  logic [15:0] word,
  output logic [15:0] folded
);
  localparam int EXT_W = $clog2(HDR_WORDS);
  localparam int ACC_W = 16 + EXT_W;

  logic [ACC_W-1:0] acc;
  logic [16:0]      fold1;

  always_ff @(posedge clk) begin
    if (rst || clear) acc <= '0;
    else if (wordEn)  acc <= acc + ACC_W'(word);
  end

  // Two end-around folds reach 16 bits, since the extension is narrower than 16.
  assign fold1  = {1'b0, acc[15:0]} + 17'(acc[ACC_W-1:16]);
  assign folded = fold1[15:0] + 16'(fold1[16]);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    int'(acc[ACC_W-1:16]) < HDR_WORDS);

endmodule

// File: rtl/ipv4_ext_dp.sv
module ipv4_ext_dp
  import ipv4_ext_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int HDR_START = 14,
  parameter int HDR_LEN   = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrl_strobe_t       stb,
  input  logic [IDX_W-1:0]   byteIdx,
  input  logic [7:0]         rxByte,
  output logic               etMatch,
  output logic               allPass,
  output logic               csumOk,
  output logic               csumErr,
  output logic               verErr,
  output logic               ihlErr,
  output logic [7:0]         verIhl,
  output logic [15:0]        totLen,
  output logic [7:0]         proto,
  output logic [31:0]        srcAddr,
  output logic [31:0]        dstAddr
);
  localparam int HDR_WORDS  = HDR_LEN / 2;
  localparam int ADDR_BYTES = 4;
  localparam int OFF_VER    = 0;
  localparam int OFF_LEN    = 2;
  localparam int OFF_PROTO  = 9;
  localparam int OFF_SRC    = 12;
  localparam int OFF_DST    = OFF_SRC + ADDR_BYTES;

  logic [IDX_W-1:0] hdrOff;
  logic [7:0]       etHi;
  logic [7:0]       wordHi;
  logic [15:0]      foldedSum;
  logic             chkVer, chkIhl, chkSum;

  assign hdrOff = byteIdx - IDX_W'(HDR_START);

  always_ff @(posedge clk) begin
    if (rst) etHi <= '0;
    else if (stb.etHiLoad) etHi <= rxByte;
  end
  assign etMatch = ({etHi, rxByte} == 16'h0800);

  // Even header offsets hold the high byte of each checksum word.
  always_ff @(posedge clk) begin
    if (rst || stb.clearAll) wordHi <= '0;
    else if (stb.hdrCapture && !hdrOff[0]) wordHi <= rxByte;
  end

  ipv4_csum_acc #(.HDR_WORDS(HDR_WORDS)) csum_i (
    .clk    (clk),
    .rst    (rst),
    .clear  (stb.clearAll),
    .wordEn (stb.hdrCapture && hdrOff[0]),
    .word   ({wordHi, rxByte}),
    .folded (foldedSum)
  );

  always_ff @(posedge clk) begin
    if (rst || stb.clearAll) begin
      verIhl <= '0;
      totLen <= '0;
      proto  <= '0;
    end else if (stb.hdrCapture) begin
      if (hdrOff == IDX_W'(OFF_VER))     verIhl       <= rxByte;
      if (hdrOff == IDX_W'(OFF_LEN))     totLen[15:8] <= rxByte;
      if (hdrOff == IDX_W'(OFF_LEN + 1)) totLen[7:0]  <= rxByte;
      if (hdrOff == IDX_W'(OFF_PROTO))   proto        <= rxByte;
    end
  end

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    logic [7:0] srcQ, dstQ;
    always_ff @(posedge clk) begin
      if (rst || stb.clearAll) begin
        srcQ <= '0;
        dstQ <= '0;
      end else if (stb.hdrCapture) begin
        if (hdrOff == IDX_W'(OFF_SRC + g)) srcQ <= rxByte;
        if (hdrOff == IDX_W'(OFF_DST + g)) dstQ <= rxByte;
      end
    end
    // Lowest index lands in the most significant byte.
    assign srcAddr[8*(ADDR_BYTES-1-g) +: 8] = srcQ;
    assign dstAddr[8*(ADDR_BYTES-1-g) +: 8] = dstQ;
  end

  assign chkVer  = (verIhl[7:4] == 4'd4);
  assign chkIhl  = (verIhl[3:0] == 4'd5);
  assign chkSum  = (foldedSum == 16'hFFFF);
  assign allPass = chkVer && chkIhl && chkSum;

  always_ff @(posedge clk) begin
    if (rst || stb.clearAll) begin
      csumOk  <= 1'b0;
      csumErr <= 1'b0;
      verErr  <= 1'b0;
      ihlErr  <= 1'b0;
    end else if (stb.setFlags) begin
      csumOk  <= chkSum;
      csumErr <= !chkSum;
      verErr  <= !chkVer;
      ihlErr  <= !chkIhl;
    end
  end

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!stb.clearAll && !stb.setFlags) |=> $stable({csumOk, csumErr, verErr, ihlErr}));

  // R10
  fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!stb.clearAll && !stb.hdrCapture) |=> $stable({verIhl, totLen, proto, srcAddr, dstAddr}));

  // R4
  csum_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(csumOk && csumErr));

endmodule

// File: rtl/ipv4_ext_ctrl.sv
module ipv4_ext_ctrl
  import ipv4_ext_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int ET_HI_IDX = 12,
  parameter int HDR_START = 14,
  parameter int HDR_LEN   = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frameValid,
  input  logic [IDX_W-1:0] byteIdx,
  input  logic             etMatch,
  input  logic             allPass,
  output ctrl_strobe_t     stb,
  output logic             hdrValid
);
  localparam int ET_LO_IDX = ET_HI_IDX + 1;
  localparam int HDR_END   = HDR_START + HDR_LEN - 1;

  fsm_state_t state, nextState;
  logic inHdr;

  assign inHdr = (byteIdx >= IDX_W'(HDR_START)) && (byteIdx <= IDX_W'(HDR_END));

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (frameValid && byteIdx == '0) begin
          stb.clearAll = 1'b1;
          nextState    = ST_WAIT_ET;
        end
      end
      ST_WAIT_ET: begin
        if (!frameValid) nextState = ST_IDLE;
        else if (byteIdx == IDX_W'(ET_HI_IDX)) stb.etHiLoad = 1'b1;
        else if (byteIdx == IDX_W'(ET_LO_IDX)) nextState = etMatch ? ST_PARSE : ST_IDLE;
      end
      ST_PARSE: begin
        if (!frameValid) nextState = ST_IDLE;
        else if (inHdr) begin
          stb.hdrCapture = 1'b1;
          if (byteIdx == IDX_W'(HDR_END)) nextState = ST_CHECK;
        end
      end
      ST_CHECK: begin
        stb.setFlags = 1'b1;
        nextState    = allPass ? ST_EMIT : ST_IDLE;
      end
      ST_EMIT: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  assign hdrValid = (state == ST_EMIT);

  // R7
  emit_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    hdrValid |=> !hdrValid);

  // R7
  emit_after_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EMIT) |-> ($past(state) == ST_CHECK && $past(allPass)));

  // R2
  parse_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PARSE && $past(state) == ST_WAIT_ET) |-> $past(etMatch));

  // R9
  abandon_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_WAIT_ET || state == ST_PARSE) && !frameValid) |=> (state == ST_IDLE));

endmodule

// File: rtl/ipv4_hdr_extract.sv
module ipv4_hdr_extract
  import ipv4_ext_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int ET_HI_IDX = 12,
  parameter int HDR_START = 14,
  parameter int HDR_LEN   = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frameValid,
  input  logic [IDX_W-1:0] byteIdx,
  input  logic [7:0]       rxByte,
  output logic             hdrValid,
  output logic             csumOk,
  output logic             csumErr,
  output logic             verErr,
  output logic             ihlErr,
  output logic [7:0]       verIhl,
  output logic [15:0]      totLen,
  output logic [7:0]       proto,
  output logic [31:0]      srcAddr,
  output logic [31:0]      dstAddr
);
  ctrl_strobe_t stb;
  logic etMatch, allPass;

  ipv4_ext_ctrl #(
    .IDX_W(IDX_W), .ET_HI_IDX(ET_HI_IDX), .HDR_START(HDR_START), .HDR_LEN(HDR_LEN)
  ) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .frameValid (frameValid),
    .byteIdx    (byteIdx),
    .etMatch    (etMatch),
    .allPass    (allPass),
    .stb        (stb),
    .hdrValid   (hdrValid)
  );

  ipv4_ext_dp #(
    .IDX_W(IDX_W), .HDR_START(HDR_START), .HDR_LEN(HDR_LEN)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .byteIdx (byteIdx),
    .rxByte  (rxByte),
    .etMatch (etMatch),
    .allPass (allPass),
    .csumOk  (csumOk),
    .csumErr (csumErr),
    .verErr  (verErr),
    .ihlErr  (ihlErr),
    .verIhl  (verIhl),
    .totLen  (totLen),
    .proto   (proto),
    .srcAddr (srcAddr),
    .dstAddr (dstAddr)
  );

  // R7
  pulse_clean_chk: assert property (@(posedge clk) disable iff (rst)
    hdrValid |-> (csumOk && !csumErr && !verErr && !ihlErr));

endmodule

// File: tb/ipv4_hdr_extract_tb.sv
module ipv4_hdr_extract_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HDR_BYTES  = 34;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frameValid = 1'b0;
  logic [5:0]  byteIdx = '0;
  logic [7:0]  rxByte = '0;
  logic        hdrValid, csumOk, csumErr, verErr, ihlErr;
  logic [7:0]  verIhl, proto;
  logic [15:0] totLen;
  logic [31:0] srcAddr, dstAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] frm [0:HDR_BYTES-1];

  int pulseCnt = 0, runLen = 0, maxRun = 0;
  logic [31:0] snapSrc, snapDst;
  logic [7:0]  snapProto;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipv4_hdr_extract dut_i (
    .clk(clk), .rst(rst), .frameValid(frameValid), .byteIdx(byteIdx), .rxByte(rxByte),
    .hdrValid(hdrValid), .csumOk(csumOk), .csumErr(csumErr), .verErr(verErr),
    .ihlErr(ihlErr), .verIhl(verIhl), .totLen(totLen), .proto(proto),
    .srcAddr(srcAddr), .dstAddr(dstAddr)
  );

  always @(negedge clk) begin
    if (hdrValid) begin
      pulseCnt++;
      runLen++;
      snapSrc   = srcAddr;
      snapDst   = dstAddr;
      snapProto = proto;
    end else runLen = 0;
    if (runLen > maxRun) maxRun = runLen;
  end

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] onesSum();
    int unsigned s = 0;
    for (int k = 0; k < 10; k++) s += {frm[14+2*k], frm[15+2*k]};
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    return s[15:0];
  endfunction

  task automatic makeFrame(input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] vi,
                           input logic [15:0] tl, input logic [7:0] pr,
                           input logic [31:0] s, input logic [31:0] d, input bit badSum);
    logic [15:0] c;
    for (int i = 0; i < HDR_BYTES; i++) frm[i] = 8'($urandom);
    frm[12] = e0; frm[13] = e1; frm[14] = vi;
    frm[16] = tl[15:8]; frm[17] = tl[7:0]; frm[23] = pr;
    for (int i = 0; i < 4; i++) begin
      frm[26+i] = s[31-8*i -: 8];
      frm[30+i] = d[31-8*i -: 8];
    end
    frm[24] = 8'h00; frm[25] = 8'h00;
    c = ~onesSum();
    frm[24] = c[15:8]; frm[25] = c[7:0];
    if (badSum) frm[25] = frm[25] ^ 8'h01;
  endtask

  task automatic sendFrame(input int payLen, input int cutAt);
    pulseCnt = 0; maxRun = 0;
    for (int i = 0; i < HDR_BYTES + payLen; i++) begin
      if (i == cutAt) break;
      @(negedge clk);
      frameValid = 1'b1;
      byteIdx    = 6'(i);
      rxByte     = (i < HDR_BYTES) ? frm[i] : 8'($urandom);
    end
    @(negedge clk);
    frameValid = 1'b0; byteIdx = '0; rxByte = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic runFrame(input string name, input int payLen, input int cutAt);
    bit et, vOk, iOk, sOk, cut;
    logic [31:0] s, d;
    et  = (frm[12] == 8'h08) && (frm[13] == 8'h00);
    vOk = frm[14][7:4] == 4'd4;
    iOk = frm[14][3:0] == 4'd5;
    sOk = onesSum() == 16'hFFFF;
    cut = cutAt < HDR_BYTES;
    s = {frm[26], frm[27], frm[28], frm[29]};
    d = {frm[30], frm[31], frm[32], frm[33]};
    sendFrame(payLen, cutAt);
    if (cut) begin
      // R9 abandoned frame
      chkEq({name, " R9 pulses"}, pulseCnt, 0);
      chkEq({name, " R9 flags"}, {verErr, ihlErr, csumErr, csumOk}, 0);
    end else begin
      // R7 pulse only when all checks pass, exactly one cycle
      chkEq({name, " R7 pulses"}, pulseCnt, (et && vOk && iOk && sOk) ? 1 : 0);
      chkEq({name, " R7 width"}, maxRun, (et && vOk && iOk && sOk) ? 1 : 0);
      // R5 R6 R4 R11 flags; R2 none for foreign type
      chkEq({name, " R5 verErr"}, verErr, et && !vOk);
      chkEq({name, " R6 ihlErr"}, ihlErr, et && !iOk);
      chkEq({name, " R4 csumErr"}, csumErr, et && !sOk);
      chkEq({name, " R4 csumOk"}, csumOk, et && sOk);
      // R3 R10 captured fields held after payload
      chkEq({name, " R3 verIhl"}, verIhl, et ? frm[14] : 8'h00);
      chkEq({name, " R3 totLen"}, totLen, et ? {frm[16], frm[17]} : 16'h0);
      chkEq({name, " R3 proto"}, proto, et ? frm[23] : 8'h00);
      chkEq({name, " R3 srcAddr"}, srcAddr, et ? s : 32'h0);
      chkEq({name, " R3 dstAddr"}, dstAddr, et ? d : 32'h0);
      if (pulseCnt == 1) begin
        chkEq({name, " R3 src at pulse"}, snapSrc, s);
        chkEq({name, " R3 dst at pulse"}, snapDst, d);
        chkEq({name, " R3 proto at pulse"}, snapProto, frm[23]);
      end
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    chkEq("R1 in reset", {hdrValid, csumOk, csumErr, verErr, ihlErr, verIhl, proto}, 0);
    rst = 1'b0;
    @(negedge clk);
    chkEq("R1 after reset fields", {totLen, srcAddr} , 0);
    chkEq("R1 after reset dst", dstAddr, 0);

    makeFrame(8'h08, 8'h00, 8'h45, 16'd60, 8'h11, 32'hC0A8010A, 32'hC0A80164, 0);
    runFrame("udp", 0, 99);
    makeFrame(8'h08, 8'h00, 8'h45, 16'd40, 8'h06, 32'h0A000001, 32'h0A000002, 0);
    runFrame("tcp+payload R10", 10, 99);
    makeFrame(8'h08, 8'h00, 8'h45, 16'd60, 8'h11, 32'h01020304, 32'h05060708, 1);
    runFrame("badsum", 0, 99);
    makeFrame(8'h08, 8'h00, 8'h65, 16'd60, 8'h11, 32'h11223344, 32'h55667788, 0);
    runFrame("ver6", 2, 99);
    // R8 flags and fields held, then cleared at next frame start
    repeat (5) @(negedge clk);
    chkEq("R8 verErr held", verErr, 1);
    chkEq("R8 src held", srcAddr, 32'h11223344);
    frameValid = 1'b1; byteIdx = '0; rxByte = 8'hAA;
    @(negedge clk);
    frameValid = 1'b0;
    chkEq("R8 flags cleared at start", {verErr, ihlErr, csumErr, csumOk}, 0);
    chkEq("R8 src cleared at start", srcAddr, 0);
    repeat (3) @(negedge clk);
    makeFrame(8'h08, 8'h00, 8'h46, 16'd64, 8'h01, 32'hAABBCCDD, 32'h01010101, 0);
    runFrame("ihl6", 0, 99);
    makeFrame(8'h08, 8'h06, 8'h45, 16'd28, 8'h11, 32'h0A0A0A0A, 32'h0B0B0B0B, 0);
    runFrame("arp R2", 0, 99);
    makeFrame(8'h00, 8'h08, 8'h45, 16'd28, 8'h11, 32'h0A0A0A0A, 32'h0B0B0B0B, 0);
    runFrame("swapped type R2", 0, 99);
    makeFrame(8'h08, 8'h00, 8'h67, 16'd60, 8'h11, 32'h0C0C0C0C, 32'h0D0D0D0D, 1);
    runFrame("multi R11", 0, 99);
    makeFrame(8'h08, 8'h00, 8'h45, 16'd60, 8'h11, 32'h0E0E0E0E, 32'h0F0F0F0F, 0);
    runFrame("cut33 R9", 0, 33);
    makeFrame(8'h08, 8'h00, 8'h45, 16'd60, 8'h11, 32'hFFFFFFFF, 32'hFFFFFFFF, 0);
    runFrame("all-ones addr", 0, 99);

    for (int n = 0; n < 60; n++) begin
      int sel, cutAt;
      logic [7:0] e1, vi;
      sel   = int'($urandom_range(0, 9));
      e1    = (sel == 0) ? 8'h06 : 8'h00;
      vi    = {(sel == 1) ? 4'd6 : 4'd4, (sel == 2) ? 4'd7 : 4'd5};
      cutAt = (sel == 3) ? int'($urandom_range(1, 33)) : 99;
      makeFrame(8'h08, e1, vi, 16'($urandom), 8'($urandom), $urandom, $urandom, sel == 4);
      runFrame("random", int'($urandom_range(0, 8)), cutAt);
    end

    finished = 1;
    finish_run();
  end
endmodule